// File: doc/BRIEF.md
# Interrupt Entry and Return Stacking Sequencer

This block sits next to a small 8-bit processor core and takes over the memory traffic of interrupt entry and interrupt return. When the core reports an instruction boundary and a request that is not masked, the sequencer captures a snapshot of the register file. It writes a fixed nine-byte frame onto a downward-growing byte stack, one byte per clock. It then reads a 16-bit handler address from two consecutive bytes and presents the new register values, with the mask bits raised, for the core to load.

When the core raises the return strobe, the sequencer reads the nine bytes back in the opposite order and presents the restored register set, including the saved condition code byte. This returns both mask bits to the state they had before the interrupt. The core loads the presented values on the one-cycle `done` strobe. `busy` marks the cycles in which the sequencer owns the memory port. Instruction decode and execution stay in the core.

Top module: `irq_stack_seq`

## Requirements
- R1: A request is accepted only in a cycle where `at_boundary` is 1 and the sequencer is idle. The first frame write appears in the cycle after the accepting clock edge. With `at_boundary` at 0, nothing happens.
- R2: Entry writes exactly nine bytes, one per cycle. The bytes in write order are PC[7:0], PC[15:8], Y[7:0], Y[15:8], X[7:0], X[15:8], A, B, CCR. Write k (k = 0..8) goes to address SP0-1-k, where SP0 is `sp` before entry.
- R3: `sp` resets to SP_RESET (default 16'h0080) and drops by one on every frame write, ending at SP0-9 after entry.
- R4: After the ninth write, the sequencer reads `vec_addr` and then `vec_addr`+1, one per cycle. The first byte becomes `out_pc[15:8]` and the second becomes `out_pc[7:0]`. Y, X, A and B are presented unchanged.
- R5: CCR bit 4 is the maskable-request mask (I) and bit 6 is the non-maskable mask (X). `irq_req` is taken only when `snap_ccr[4]` is 0 and sets bit 4 in `out_ccr`. `nmi_req` is taken only when `snap_ccr[6]` is 0 and sets bits 6 and 4. Other CCR bits pass unchanged. When both requests qualify, the non-maskable one wins.
- R6: On `ret_req`, the sequencer reads nine bytes at `sp`, `sp`+1, ... `sp`+8, one per cycle. The CCR comes first and PC[7:0] last, in exact reverse of the write order. The restored values, including the saved CCR, are presented on the outputs and `sp` rises by nine.
- R7: `busy` is 1 in every cycle that has a memory access and 0 otherwise. `done` is a one-cycle pulse in the cycle after the last access, with `busy` at 0, and the `out_*` values change only then.
- R8: Requests and return strobes that arrive while `busy` is 1 are ignored.
- R9: When `ret_req` and a qualifying request arrive together at idle, the return is carried out and the request is dropped.
- R10: During and right after reset, the sequencer is idle. `busy` and `done` are 0, no memory access is made, `sp` equals SP_RESET and all `out_*` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Core is between instructions |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable external request |
| ret_req | input | 1 | Return-from-interrupt strobe |
| vec_addr | input | 16 | Address of the handler vector high byte |
| snap_pc | input | 16 | Return address snapshot |
| snap_y | input | 16 | Y index register snapshot |
| snap_x | input | 16 | X index register snapshot |
| snap_a | input | 8 | Accumulator A snapshot |
| snap_b | input | 8 | Accumulator B snapshot |
| snap_ccr | input | 8 | Condition code snapshot |
| mem_we | output | 1 | Memory byte write enable |
| mem_re | output | 1 | Memory byte read enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Sequencer owns the memory port |
| done | output | 1 | Load strobe for the out_* values |
| out_pc | output | 16 | Program counter to load |
| out_y | output | 16 | Y to load |
| out_x | output | 16 | X to load |
| out_a | output | 8 | A to load |
| out_b | output | 8 | B to load |
| out_ccr | output | 8 | Condition codes to load |

## Verification
A wrong step count or state shows up at the memory port in the very next cycle. It appears as a write to the wrong address, a wrong frame byte, or a read where a write belongs. A drifting stack pointer shows in `sp` on the cycle it goes wrong. A corrupted capture of the frame or vector shows only at the `done` cycle, through `out_*`. A mask mistake shows there too, as a wrong `out_ccr` bit after entry or a failure to restore it after return. Comparing every port in every cycle against a behavioural model therefore pins each fault to the cycle where it first appears.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;
  localparam int ADDR_W  = 16;
  localparam int FRAME_N = 9;
  localparam int VEC_N   = 2;
  localparam int STEP_W  = $clog2(FRAME_N);
  localparam int CCR_I   = 4;
  localparam int CCR_X   = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VEC, ST_POP} seq_st_t;

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] y;
    logic [15:0] x;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  ccr;
  } regset_t;

  // byte written at push step k (return address first, condition codes last)
  function automatic logic [7:0] push_byte(input regset_t r, input logic [STEP_W-1:0] k);
    case (k)
      4'd0:    return r.pc[7:0];
      4'd1:    return r.pc[15:8];
      4'd2:    return r.y[7:0];
      4'd3:    return r.y[15:8];
      4'd4:    return r.x[7:0];
      4'd5:    return r.x[15:8];
      4'd6:    return r.a;
      4'd7:    return r.b;
      default: return r.ccr;
    endcase
  endfunction

  // place the byte read at pop step k into its register slot
  function automatic regset_t pop_place(input regset_t r, input logic [STEP_W-1:0] k,
                                        input logic [7:0] d);
    regset_t t;
    t = r;
    case (k)
      4'd0:    t.ccr       = d;
      4'd1:    t.b         = d;
      4'd2:    t.a         = d;
      4'd3:    t.x[15:8]   = d;
      4'd4:    t.x[7:0]    = d;
      4'd5:    t.y[15:8]   = d;
      4'd6:    t.y[7:0]    = d;
      4'd7:    t.pc[15:8]  = d;
      default: t.pc[7:0]   = d;
    endcase
    return t;
  endfunction

  function automatic logic [7:0] entry_ccr(input logic [7:0] c, input logic nmi);
    logic [7:0] t;
    t = c;
    t[CCR_I] = 1'b1;
    if (nmi) t[CCR_X] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_go,
  input  logic              pop_go,
  output seq_st_t           st,
  output logic [STEP_W-1:0] step,
  output logic              fin_entry,
  output logic              fin_ret
);
  localparam logic [STEP_W-1:0] FRAME_LAST = STEP_W'(FRAME_N - 1);
  localparam logic [STEP_W-1:0] VEC_LAST   = STEP_W'(VEC_N - 1);

  assign fin_entry = (st == ST_VEC) && (step == VEC_LAST);
  assign fin_ret   = (st == ST_POP) && (step == FRAME_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      step <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          step <= '0;
          if (pop_go)       st <= ST_POP;
          else if (push_go) st <= ST_PUSH;
        end
        ST_PUSH: begin
          if (step == FRAME_LAST) begin
            st   <= ST_VEC;
            step <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_VEC: begin
          if (fin_entry) begin
            st   <= ST_IDLE;
            step <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: begin
          if (fin_ret) begin
            st   <= ST_IDLE;
            step <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_frame_store.sv
module irq_frame_store
  import irq_stack_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_go,
  input  logic              nmi_sel,
  input  regset_t           snap,
  input  logic [ADDR_W-1:0] vec_in,
  input  seq_st_t           st,
  input  logic [STEP_W-1:0] step,
  input  logic [7:0]        rdata,
  output regset_t           frame,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] vec,
  output logic              nmi_f,
  output logic [7:0]        vhi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame <= '0;
      sp    <= SP_RESET;
      vec   <= '0;
      nmi_f <= 1'b0;
      vhi   <= '0;
    end else begin
      if (push_go) begin
        frame <= snap;
        vec   <= vec_in;
        nmi_f <= nmi_sel;
      end
      case (st)
        ST_PUSH: sp <= sp - 1'b1;
        ST_POP: begin
          sp    <= sp + 1'b1;
          frame <= pop_place(frame, step, rdata);
        end
        ST_VEC: if (step == '0) vhi <= rdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_mem_port.sv
module irq_mem_port
  import irq_stack_pkg::*;
(
  input  seq_st_t           st,
  input  logic [STEP_W-1:0] step,
  input  regset_t           frame,
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] vec,
  output logic              we,
  output logic              re,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata
);
  always_comb begin
    we    = 1'b0;
    re    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (st)
      ST_PUSH: begin
        we    = 1'b1;
        addr  = sp - 1'b1;
        wdata = push_byte(frame, step);
      end
      ST_VEC: begin
        re   = 1'b1;
        addr = vec + {{(ADDR_W-STEP_W){1'b0}}, step};
      end
      ST_POP: begin
        re   = 1'b1;
        addr = sp;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_stack_pkg::*;
#(
  parameter logic [15:0] SP_RESET = 16'h0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        at_boundary,
  input  logic        irq_req,
  input  logic        nmi_req,
  input  logic        ret_req,
  input  logic [15:0] vec_addr,
  input  logic [15:0] snap_pc,
  input  logic [15:0] snap_y,
  input  logic [15:0] snap_x,
  input  logic [7:0]  snap_a,
  input  logic [7:0]  snap_b,
  input  logic [7:0]  snap_ccr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] sp,
  output logic        busy,
  output logic        done,
  output logic [15:0] out_pc,
  output logic [15:0] out_y,
  output logic [15:0] out_x,
  output logic [7:0]  out_a,
  output logic [7:0]  out_b,
  output logic [7:0]  out_ccr
);
  seq_st_t           st;
  logic [STEP_W-1:0] step;
  logic              fin_entry, fin_ret;
  regset_t           frame, snap, outr, next_out;
  logic [15:0]       vec;
  logic              nmi_f;
  logic [7:0]        vhi;

  // named acceptance events
  logic idle, nmi_ok, irq_ok, push_go, pop_go;
  assign idle    = (st == ST_IDLE);
  assign nmi_ok  = at_boundary && nmi_req && !snap_ccr[CCR_X];
  assign irq_ok  = at_boundary && irq_req && !snap_ccr[CCR_I];
  assign pop_go  = idle && ret_req;
  assign push_go = idle && !ret_req && (nmi_ok || irq_ok);
  assign busy    = !idle;

  assign snap = '{pc: snap_pc, y: snap_y, x: snap_x, a: snap_a, b: snap_b, ccr: snap_ccr};

  irq_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_go(push_go), .pop_go(pop_go),
    .st(st), .step(step), .fin_entry(fin_entry), .fin_ret(fin_ret)
  );

  irq_frame_store #(.SP_RESET(SP_RESET)) u_store (
    .clk(clk), .rst_n(rst_n), .push_go(push_go), .nmi_sel(nmi_ok), .snap(snap),
    .vec_in(vec_addr), .st(st), .step(step), .rdata(mem_rdata),
    .frame(frame), .sp(sp), .vec(vec), .nmi_f(nmi_f), .vhi(vhi)
  );

  irq_mem_port u_port (
    .st(st), .step(step), .frame(frame), .sp(sp), .vec(vec),
    .we(mem_we), .re(mem_re), .addr(mem_addr), .wdata(mem_wdata)
  );

  always_comb begin
    next_out = outr;
    if (fin_entry) begin
      next_out     = frame;
      next_out.pc  = {vhi, mem_rdata};
      next_out.ccr = entry_ccr(frame.ccr, nmi_f);
    end else if (fin_ret) begin
      next_out = pop_place(frame, step, mem_rdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outr <= '0;
      done <= 1'b0;
    end else begin
      outr <= next_out;
      done <= fin_entry || fin_ret;
    end
  end

  assign out_pc  = outr.pc;
  assign out_y   = outr.y;
  assign out_x   = outr.x;
  assign out_a   = outr.a;
  assign out_b   = outr.b;
  assign out_ccr = outr.ccr;
endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] sp,
  input logic        fin_entry,
  input logic        push_go,
  input logic [7:0]  out_ccr
);
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R2
  AST_SP_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 16'd1)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re)); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_ENTRY_MASK_I: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fin_entry) |-> out_ccr[4]); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> busy); // R1
endmodule

bind irq_stack_seq irq_stack_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
  .mem_re(mem_re), .sp(sp), .fin_entry(fin_entry), .push_go(push_go),
  .out_ccr(out_ccr)
);

// File: tb/sim_irq_stack_seq.sv
`timescale 1ns/1ps
module sim_irq_stack_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic at_boundary = 0, irq_req = 0, nmi_req = 0, ret_req = 0;
  logic [15:0] vec_addr = 0, snap_pc = 0, snap_y = 0, snap_x = 0;
  logic [7:0]  snap_a = 0, snap_b = 0, snap_ccr = 0;
  logic        mem_we, mem_re, busy, done;
  logic [15:0] mem_addr, sp, out_pc, out_y, out_x;
  logic [7:0]  mem_wdata, mem_rdata, out_a, out_b, out_ccr;

  always #2 clk = ~clk;

  irq_stack_seq u0 (.*);

  // byte memory, low address byte selects the location
  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  typedef struct {
    bit busy, we, re, done, chk;
    logic [15:0] addr, sp;
    logic [7:0]  wd;
    logic [71:0] outv;
    string       tag;
  } exp_t;

  exp_t        eq[$];
  logic [7:0]  stk[$];
  logic [15:0] model_sp = 16'h0080;
  int checks = 0, errors = 0;

  function automatic exp_t blank(string tag, logic [15:0] s);
    exp_t e;
    e.busy = 0; e.we = 0; e.re = 0; e.done = 0; e.chk = 0;
    e.addr = 0; e.sp = s; e.wd = 0; e.outv = 0; e.tag = tag;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic compare_now();
    exp_t e;
    if (eq.size() > 0) e = eq.pop_front();
    else e = blank("R7", model_sp);
    chk(busy === e.busy && done === e.done, e.tag, {busy, done}, {e.busy, e.done});
    chk(mem_we === e.we && mem_re === e.re, e.tag, {mem_we, mem_re}, {e.we, e.re});
    chk(sp === e.sp, {e.tag, " R3 sp"}, sp, e.sp);
    if (e.we || e.re) chk(mem_addr === e.addr, {e.tag, " addr"}, mem_addr, e.addr);
    if (e.we) chk(mem_wdata === e.wd, {e.tag, " wdata"}, mem_wdata, e.wd);
    if (e.chk)
      chk({out_pc, out_y, out_x, out_a, out_b, out_ccr} === e.outv, {e.tag, " regs"},
          {out_pc, out_y, out_x, out_a, out_b, out_ccr}, e.outv);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_now();
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic enq_entry(input logic [15:0] pcv, yv, xv, input logic [7:0] av, bv, cv,
                           input logic [15:0] v, input bit nmi);
    logic [7:0] fb [9];
    exp_t e;
    logic [7:0] c;
    fb = '{pcv[7:0], pcv[15:8], yv[7:0], yv[15:8], xv[7:0], xv[15:8], av, bv, cv};
    for (int k = 0; k < 9; k++) begin
      e = blank("R2", model_sp - 16'(k));
      e.busy = 1; e.we = 1; e.addr = model_sp - 16'(k) - 16'd1; e.wd = fb[k];
      eq.push_back(e);
      stk.push_back(fb[k]);
    end
    for (int k = 0; k < 2; k++) begin
      e = blank("R4", model_sp - 16'd9);
      e.busy = 1; e.re = 1; e.addr = v + 16'(k);
      eq.push_back(e);
    end
    c = cv | 8'h10 | (nmi ? 8'h40 : 8'h00);
    e = blank("R5", model_sp - 16'd9);
    e.done = 1; e.chk = 1;
    e.outv = {mem[v[7:0]], mem[8'(v[7:0] + 8'd1)], yv, xv, av, bv, c};
    eq.push_back(e);
    model_sp = model_sp - 16'd9;
  endtask

  task automatic enq_pop();
    logic [7:0] pb [9];
    exp_t e;
    for (int k = 0; k < 9; k++) begin
      e = blank("R6", model_sp + 16'(k));
      e.busy = 1; e.re = 1; e.addr = model_sp + 16'(k);
      pb[k] = stk.pop_back();
      eq.push_back(e);
    end
    e = blank("R6", model_sp + 16'd9);
    e.done = 1; e.chk = 1;
    e.outv = {pb[7], pb[8], pb[5], pb[6], pb[3], pb[4], pb[2], pb[1], pb[0]};
    eq.push_back(e);
    model_sp = model_sp + 16'd9;
  endtask

  task automatic issue(input bit r, input bit n, input bit i, input bit bd, input logic [7:0] c,
                       input logic [15:0] pcv, yv, xv, input logic [7:0] av, bv,
                       input logic [15:0] v, input string tag);
    ret_req = r; nmi_req = n; irq_req = i; at_boundary = bd; snap_ccr = c;
    snap_pc = pcv; snap_y = yv; snap_x = xv; snap_a = av; snap_b = bv; vec_addr = v;
    if (eq.size() == 0) begin
      if (r) enq_pop();
      else if (bd && n && !c[6]) enq_entry(pcv, yv, xv, av, bv, c, v, 1'b1);
      else if (bd && i && !c[4]) enq_entry(pcv, yv, xv, av, bv, c, v, 1'b0);
    end
    if (eq.size() > 0) eq[0].tag = tag;
    else eq.push_back(blank(tag, model_sp));
    tick();
    ret_req = 0; nmi_req = 0; irq_req = 0; at_boundary = 0; snap_ccr = 0;
    snap_pc = 0; snap_y = 0; snap_x = 0; snap_a = 0; snap_b = 0; vec_addr = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R7 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'(k) ^ 8'h5A;
    mem[8'hF2] = 8'h20; mem[8'hF3] = 8'h40;
    mem[8'hF4] = 8'h31; mem[8'hF5] = 8'h7E;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(busy === 0 && done === 0 && mem_we === 0 && mem_re === 0, "R10 ctl",
        {busy, done, mem_we, mem_re}, 0);
    chk(sp === 16'h0080, "R10 sp", sp, 16'h0080);
    chk({out_pc, out_y, out_x, out_a, out_b, out_ccr} === 72'd0, "R10 regs",
        {out_pc, out_y, out_x, out_a, out_b, out_ccr}, 0);
    idle(2);
    // maskable entry, mask I clear
    issue(0, 0, 1, 1, 8'h85, 16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 16'hFFF2, "R1");
    idle(2);
    // R8: strobes during busy are dropped
    issue(1, 1, 1, 1, 8'h00, 16'hAAAA, 16'hBBBB, 16'hCCCC, 8'h33, 8'h44, 16'hFFF4, "R8");
    idle(12);
    issue(1, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R6");
    idle(12);
    // non-maskable entry while I is set
    issue(0, 1, 0, 1, 8'h10, 16'h4321, 16'h0F0E, 16'h7654, 8'hA5, 8'h5A, 16'hFFF4, "R5");
    idle(13);
    // masked or off-boundary requests are ignored
    issue(0, 0, 1, 1, 8'h10, 16'h1111, 0, 0, 0, 0, 16'hFFF2, "R5");
    idle(2);
    issue(0, 1, 0, 1, 8'h40, 16'h2222, 0, 0, 0, 0, 16'hFFF4, "R5");
    idle(2);
    issue(0, 0, 1, 0, 8'h00, 16'h3333, 0, 0, 0, 0, 16'hFFF2, "R1");
    idle(2);
    // R9: return wins over a simultaneous request
    issue(1, 0, 1, 1, 8'h00, 16'h4444, 0, 0, 0, 0, 16'hFFF2, "R9");
    idle(12);
    // both sources at once: non-maskable chosen
    issue(0, 1, 1, 1, 8'h01, 16'hBEEF, 16'h0102, 16'h0304, 8'h05, 8'h06, 16'hFFF2, "R5");
    idle(13);
    issue(1, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R6");
    idle(12);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule